// File: doc/BRIEF.md
# Four-Bank SDRAM Command Encoder

This block sits between a memory scheduler and the command pins of a four-bank double-data-rate SDRAM. Each cycle it may take one request: activate, read, write, precharge, refresh or mode-register load. It checks the request against the state it tracks for every bank, then drives the chip-select, row-strobe, column-strobe and write-enable pins, the bank-select bits and the address bus for one cycle. A request that is illegal for the current bank state, or that comes too soon, is refused. The block then outputs a single-cycle error pulse and sends a no-op instead. It never stalls or holds a request, so the scheduler decides whether to retry.

Each bank has an open flag, the open row, and three countdowns measured in controller cycles: activate to column access, activate to precharge, and precharge to activate. Address bit 10 has two uses. On reads and writes it requests auto-precharge. On precharge it selects between closing every bank and closing only the named bank. An auto-precharge never closes a bank before its minimum active time has passed. If the read or write comes early, the close is held back until that interval expires.

Top module: `ddr_cmd_encoder`

## Requirements
- R1: An accepted request drives, one cycle after it is sampled, the pins {cs_n,ras_n,cas_n,we_n} with these codes: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. Activate drives the requested bank and the row on cmd_addr. Read and write drive the column in cmd_addr[9:0], with cmd_addr[12:11] zero.
- R2: A cycle with no accepted request drives no-op 0111 with cmd_ba and cmd_addr zero. The same no-op is driven during and right after reset.
- R3: These requests are refused: a read or write to a closed bank, a read or write to a bank with an auto-precharge pending, and an activate to an open bank. A refused request gives req_err high for exactly the cycle its command would have occupied.
- R4: A read or write puts req_ap on cmd_addr[10]. With req_ap set, the bank closes at the sample edge if T_RAS has already elapsed. Otherwise it closes at the first edge at which T_RAS has elapsed.
- R5: Precharge puts req_ap on cmd_addr[10]. With req_ap low, only req_bank closes. With req_ap high, every bank closes and cmd_ba is driven 0.
- R6: A precharge sampled fewer than T_RAS edges after the activate of any bank it would close is refused.
- R7: A read or write sampled fewer than T_RCD edges after that bank's activate is refused.
- R8: An activate sampled fewer than T_RP edges after that bank closed is refused.
- R9: Refresh and mode load are accepted only when every bank is closed and past its T_RP interval. Mode load drives req_bank on cmd_ba and req_addr on cmd_addr.
- R10: open_mask shows one bit per bank that is open (bit n = bank n). open_row shows the row stored for the bank named by req_bank.
- R11: While req_valid is low the request fields are ignored: no-op is driven and no bank state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load |
| req_bank | input | 2 | Target bank or mode register |
| req_addr | input | 13 | Row, column or mode op code |
| req_ap | input | 1 | Auto-precharge (read/write) or all-banks (precharge) |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank select |
| cmd_addr | output | 13 | Address bus |
| req_err | output | 1 | Refusal pulse |
| open_mask | output | 4 | Open flag per bank |
| open_row | output | 13 | Stored row of bank req_bank |

## Verification
The hardest state to reach is a deferred auto-precharge. To get there, a write with auto-precharge must arrive after T_RCD but before T_RAS. Next, a read to that bank must be refused while the bank still shows open. Finally, an activate to a different bank must coincide with the edge at which the deferred close happens. The vector table places these requests on exact edge counts after the activate. It then checks that precharge-to-activate is timed from the deferred close and not from the write. Precharge-all is also driven while two banks are open with staggered ages, so that the younger bank alone decides whether it is refused.

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_addr,
  input  logic             req_ap,
  output logic             cmd_cs_n,
  output logic             cmd_ras_n,
  output logic             cmd_cas_n,
  output logic             cmd_we_n,
  output logic [BA_W-1:0]  cmd_ba,
  output logic [ROW_W-1:0] cmd_addr,
  output logic             req_err,
  output logic [(1<<BA_W)-1:0] open_mask,
  output logic [ROW_W-1:0] open_row
);
  localparam int NB = 1 << BA_W;
  localparam int TM = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                      : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int CW = $clog2(TM + 1);

  localparam logic [2:0] OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                         OP_PRE = 3'd4, OP_REF = 3'd5, OP_MRS = 3'd6;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                         C_NOP = 4'b0111;

  logic             open_q [NB];
  logic             pend_q [NB];
  logic [ROW_W-1:0] row_q  [NB];
  logic [CW-1:0]    rcd_c  [NB];
  logic [CW-1:0]    ras_c  [NB];
  logic [CW-1:0]    rp_c   [NB];

  logic all_idle, all_ras_ok, accept, do_cmd, err_n, is_rw;
  logic [3:0]       nxt_cmd;
  logic [BA_W-1:0]  nxt_ba;
  logic [ROW_W-1:0] nxt_addr;

  wire sel_open = open_q[req_bank];
  wire sel_pend = pend_q[req_bank];

  always_comb begin
    all_idle   = 1'b1;
    all_ras_ok = 1'b1;
    for (int b = 0; b < NB; b++) begin
      open_mask[b] = open_q[b];
      if (open_q[b] || rp_c[b] != '0) all_idle = 1'b0;
      if (open_q[b] && ras_c[b] != '0) all_ras_ok = 1'b0;
    end
  end

  assign open_row = row_q[req_bank];
  assign is_rw    = (req_op == OP_RD) || (req_op == OP_WR);

  always_comb begin
    accept   = 1'b0;
    nxt_cmd  = C_NOP;
    nxt_ba   = '0;
    nxt_addr = '0;
    case (req_op)
      OP_ACT: begin
        accept   = !sel_open && rp_c[req_bank] == '0;
        nxt_cmd  = C_ACT;
        nxt_ba   = req_bank;
        nxt_addr = req_addr;
      end
      OP_RD, OP_WR: begin
        accept   = sel_open && !sel_pend && rcd_c[req_bank] == '0;
        nxt_cmd  = (req_op == OP_RD) ? C_RD : C_WR;
        nxt_ba   = req_bank;
        nxt_addr[COL_W-1:0] = req_addr[COL_W-1:0];
        nxt_addr[AP_BIT]    = req_ap;
      end
      OP_PRE: begin
        accept   = req_ap ? all_ras_ok : (!sel_open || ras_c[req_bank] == '0);
        nxt_cmd  = C_PRE;
        nxt_ba   = req_ap ? '0 : req_bank;
        nxt_addr[AP_BIT] = req_ap;
      end
      OP_REF: begin
        accept  = all_idle;
        nxt_cmd = C_REF;
      end
      OP_MRS: begin
        accept   = all_idle;
        nxt_cmd  = C_MRS;
        nxt_ba   = req_bank;
        nxt_addr = req_addr;
      end
      default: ;
    endcase
  end

  assign do_cmd = req_valid && accept;
  assign err_n  = req_valid && !accept && req_op != 3'd0 && req_op != 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= C_NOP;
      cmd_ba   <= '0;
      cmd_addr <= '0;
      req_err  <= 1'b0;
    end else begin
      {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= do_cmd ? nxt_cmd : C_NOP;
      cmd_ba   <= do_cmd ? nxt_ba : '0;
      cmd_addr <= do_cmd ? nxt_addr : '0;
      req_err  <= err_n;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire hit    = req_bank == BA_W'(b);
    wire act_b  = do_cmd && req_op == OP_ACT && hit;
    wire rwap_b = do_cmd && is_rw && req_ap && hit;
    wire close_b = (do_cmd && req_op == OP_PRE && (req_ap || hit) && open_q[b])
                || (rwap_b && ras_c[b] == '0)
                || (pend_q[b] && ras_c[b] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        pend_q[b] <= 1'b0;
        row_q[b]  <= '0;
        rcd_c[b]  <= '0;
        ras_c[b]  <= '0;
        rp_c[b]   <= '0;
      end else begin
        rcd_c[b] <= rcd_c[b] - CW'(rcd_c[b] != '0);
        ras_c[b] <= ras_c[b] - CW'(ras_c[b] != '0);
        rp_c[b]  <= rp_c[b]  - CW'(rp_c[b]  != '0);
        if (act_b) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= req_addr;
          rcd_c[b]  <= CW'(T_RCD - 1);
          ras_c[b]  <= CW'(T_RAS - 1);
        end else if (close_b) begin
          open_q[b] <= 1'b0;
          pend_q[b] <= 1'b0;
          rp_c[b]   <= CW'(T_RP - 1);
        end else if (rwap_b) begin
          pend_q[b] <= 1'b1;
        end
      end
    end
  end

  wire [3:0] cmd_now = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  // R3
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_now == C_ACT |-> ((($past(open_mask) >> cmd_ba) & 1) == 0));

  // R3
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == C_RD || cmd_now == C_WR) |-> ((($past(open_mask) >> cmd_ba) & 1) != 0));

  // R9
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == C_REF || cmd_now == C_MRS) |-> $past(open_mask) == '0);

  // R2
  err_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> cmd_now == C_NOP);

  // R10
  open_by_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_mask & ~$past(open_mask)) != '0 |-> cmd_now == C_ACT);

  // R6
  pre_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_now == C_PRE |-> $countones(open_mask) <= $countones($past(open_mask)));
endmodule

// File: tb/ddr_cmd_encoder_test.sv
module ddr_cmd_encoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [2:0]  req_op = 0;
  logic [1:0]  req_bank = 0;
  logic [12:0] req_addr = 0;
  logic        req_ap = 0;
  logic        cs_n, ras_n, cas_n, we_n, req_err;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr, open_row;
  logic [3:0]  open_mask;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr_cmd_encoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .req_ap(req_ap),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .req_err(req_err),
    .open_mask(open_mask), .open_row(open_row));

  // fields: rq[46:43] op[42:40] bank[39:38] addr[37:25] ap[24]
  //         cmd[23:20] ba[19:18] addr[17:5] err[4] open[3:0]
  localparam int N = 34;
  localparam logic [46:0] VEC [N] = '{
    {4'd9,3'd6,2'd1,13'h0123,1'b0, 4'b0000,2'd1,13'h0123,1'b0,4'h0}, // R9 mode load idle
    {4'd9,3'd5,2'd0,13'h0000,1'b0, 4'b0001,2'd0,13'h0000,1'b0,4'h0}, // R9 refresh idle
    {4'd3,3'd2,2'd0,13'h0005,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h0}, // R3 read closed
    {4'd1,3'd1,2'd0,13'h1ABC,1'b0, 4'b0011,2'd0,13'h1ABC,1'b0,4'h1}, // R1 activate
    {4'd3,3'd1,2'd0,13'h0005,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h1}, // R3 act open
    {4'd7,3'd2,2'd0,13'h03FF,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h1}, // R7 early read
    {4'd1,3'd2,2'd0,13'h03FF,1'b0, 4'b0101,2'd0,13'h03FF,1'b0,4'h1}, // R1 read
    {4'd6,3'd4,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h1}, // R6 early pre
    {4'd1,3'd3,2'd0,13'h1C2A,1'b0, 4'b0100,2'd0,13'h002A,1'b0,4'h1}, // R1 write
    {4'd1,3'd1,2'd2,13'h0777,1'b0, 4'b0011,2'd2,13'h0777,1'b0,4'h5}, // R1 act bank2
    {4'd9,3'd5,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h5}, // R9 refresh busy
    {4'd5,3'd4,2'd0,13'h0000,1'b0, 4'b0010,2'd0,13'h0000,1'b0,4'h4}, // R5 single pre
    {4'd8,3'd1,2'd0,13'h0005,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h4}, // R8 early act
    {4'd6,3'd4,2'd3,13'h0000,1'b1, 4'b0111,2'd0,13'h0000,1'b1,4'h4}, // R6 early pre-all
    {4'd8,3'd1,2'd0,13'h0042,1'b0, 4'b0011,2'd0,13'h0042,1'b0,4'h5}, // R8 act at T_RP
    {4'd9,3'd6,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h5}, // R9 mode busy
    {4'd4,3'd2,2'd2,13'h0010,1'b1, 4'b0101,2'd2,13'h0410,1'b0,4'h1}, // R4 read ap late
    {4'd3,3'd2,2'd2,13'h0010,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h1}, // R3 read closed
    {4'd4,3'd3,2'd0,13'h0001,1'b1, 4'b0100,2'd0,13'h0401,1'b0,4'h1}, // R4 write ap early
    {4'd4,3'd2,2'd0,13'h0001,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h1}, // R4 pending read
    {4'd8,3'd1,2'd2,13'h1FFF,1'b0, 4'b0011,2'd2,13'h1FFF,1'b0,4'h4}, // R8 act, R4 close
    {4'd8,3'd1,2'd0,13'h0003,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h4}, // R8 early act
    {4'd2,3'd0,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b0,4'h4}, // R2 no-op
    {4'd8,3'd1,2'd0,13'h0AAA,1'b0, 4'b0011,2'd0,13'h0AAA,1'b0,4'h5}, // R8 act
    {4'd6,3'd4,2'd1,13'h0000,1'b1, 4'b0111,2'd0,13'h0000,1'b1,4'h5}, // R6 pre-all early
    {4'd2,3'd0,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b0,4'h5},
    {4'd6,3'd4,2'd2,13'h0000,1'b1, 4'b0111,2'd0,13'h0000,1'b1,4'h5}, // R6 younger bank
    {4'd2,3'd0,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b0,4'h5},
    {4'd2,3'd0,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b0,4'h5},
    {4'd5,3'd4,2'd3,13'h0000,1'b1, 4'b0010,2'd0,13'h0400,1'b0,4'h0}, // R5 pre-all
    {4'd9,3'd5,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h0}, // R9 refresh in T_RP
    {4'd2,3'd0,2'd0,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b0,4'h0},
    {4'd9,3'd5,2'd0,13'h0000,1'b0, 4'b0001,2'd0,13'h0000,1'b0,4'h0}, // R9 refresh ok
    {4'd3,3'd2,2'd3,13'h0000,1'b0, 4'b0111,2'd0,13'h0000,1'b1,4'h0}  // R3 read closed
  };

  task automatic check(input string tag, input int row, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s row %0d actual=%h expected=%h", tag, row, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input int row, input logic [3:0] c,
                           input logic [1:0] ba, input logic [12:0] ad, input logic e,
                           input logic [3:0] om);
    check(tag, row, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, c});
    check(tag, row, {30'd0, cmd_ba}, {30'd0, ba});
    check(tag, row, {19'd0, cmd_addr}, {19'd0, ad});
    check(tag, row, {31'd0, req_err}, {31'd0, e});
    check(tag, row, {28'd0, open_mask}, {28'd0, om});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R2 reset", -1, 4'b0111, 2'd0, 13'd0, 1'b0, 4'h0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_valid = 1;
      req_op    = VEC[i][42:40];
      req_bank  = VEC[i][39:38];
      req_addr  = VEC[i][37:25];
      req_ap    = VEC[i][24];
      @(negedge clk);
      check_out($sformatf("R%0d", VEC[i][46:43]), i, VEC[i][23:20], VEC[i][19:18],
                VEC[i][17:5], VEC[i][4], VEC[i][3:0]);
    end

    // R10: open row lookup for bank 1
    req_op = 3'd1; req_bank = 2'd1; req_addr = 13'h1234; req_ap = 0;
    @(negedge clk);
    req_valid = 0; req_bank = 2'd1; req_addr = 13'h0;
    check("R10 open_row", 100, {19'd0, open_row}, {19'd0, 13'h1234});
    check("R10 mask", 100, {28'd0, open_mask}, 32'h2);
    req_bank = 2'd3;
    #0.1;
    check("R10 open_row closed bank", 101, {19'd0, open_row}, 32'd0);

    // R11: fields ignored while valid is low
    req_valid = 0; req_op = 3'd1; req_bank = 2'd3; req_addr = 13'h0F0F;
    @(negedge clk);
    check_out("R11 ignored", 102, 4'b0111, 2'd0, 13'd0, 1'b0, 4'h2);
    req_op = 3'd5;
    @(negedge clk);
    check_out("R11 ignored ref", 103, 4'b0111, 2'd0, 13'd0, 1'b0, 4'h2);

    // R2: reset while a bank is open and a request is pending
    req_valid = 1; req_op = 3'd1; req_bank = 2'd2; req_addr = 13'h0055;
    rst_n = 0;
    @(negedge clk);
    check_out("R2 mid reset", 104, 4'b0111, 2'd0, 13'd0, 1'b0, 4'h0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check_out("R2 after reset", 105, 4'b0111, 2'd0, 13'd0, 1'b0, 4'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule